// File: doc/BRIEF.md
# Interleaved Partial-Sum Accumulator

This block adds up a stream of integer operands and can take a new one on every clock, even though its adder needs several cycles to produce a result. It does not feed a single accumulator back into the adder. Instead it keeps DEPTH partial sums in a chain that rotates by one position for each accepted operand. The head entry is added to the incoming operand, and the sum returns to the chain when the adder pipeline delivers it. Operand k of a stream therefore lands in lane k mod DEPTH. No addition waits for the one issued just before it, provided DEPTH exceeds the adder latency.

When the operand marked last has been accepted, the block stops taking input. It waits until every addition still in the adder has been written back. It then walks the DEPTH lanes one per cycle into a single running total. The total is presented with a one-cycle valid pulse, and the lanes are cleared at the same edge. The first operand of the next stream may already be accepted during that pulse cycle.

Top module: `ilv_accum`

## Requirements
- R1: While reset is held and in the first cycle after it is released, in_ready is 1 and sum_valid is 0.
- R2: While in_ready is 1, an operand is taken on every clock in which in_valid is 1, with no idle cycle needed between operands.
- R3: The value on sum_out during the sum_valid cycle equals the sum of all operands of the stream just finished.
- R4: Cycles without in_valid inside a stream do not change the result.
- R5: sum_valid is 1 for exactly one cycle, beginning LAT+DEPTH+1 clock edges after the edge that accepted the last operand.
- R6: in_ready is 0 from the cycle after the last operand is accepted until the sum_valid cycle, and it is 1 again in the sum_valid cycle.
- R7: An operand accepted in the sum_valid cycle starts a new stream whose sum starts from zero. No part of the previous stream carries over.
- R8: A stream of a single operand, with in_last set together with in_valid, yields that operand as the result.
- R9: Sums wrap modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_data | input | WIDTH | Operand value |
| in_last | input | 1 | Marks the final operand of a stream |
| in_ready | output | 1 | Operand is accepted when this and in_valid are both 1 |
| sum_out | output | WIDTH | Reduced sum, meaningful while sum_valid is 1 |
| sum_valid | output | 1 | One-cycle result strobe |

## Verification
Two things can happen in the same cycle: the result pulse of one stream and the acceptance of the first operand of the next. In that cycle the lanes are being cleared while the head lane is being read. The bench provokes this by offering the next stream's first operand as soon as in_ready returns. A behavioural model predicts the ready level, the pulse cycle and the sum for every clock. The new stream's total is then judged separately, and it must contain nothing left over from the old lanes.

// File: rtl/ilv_accum.sv
module ilv_accum #(
  parameter int WIDTH = 16,
  parameter int LAT   = 3,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic [WIDTH-1:0] sum_out,
  output logic             sum_valid
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_ACC, S_DRAIN, S_RED, S_DONE} st_t;

  st_t              state;
  logic [WIDTH-1:0] lane     [DEPTH];
  logic [WIDTH-1:0] pipe_sum [LAT];
  logic [CW-1:0]    pipe_cnt [LAT];
  logic [LAT-1:0]   pipe_vld;
  logic [RW-1:0]    ridx;
  logic             take, wb, red_end;
  logic [CW-1:0]    wb_pos;

  assign in_ready  = (state == S_ACC) || (state == S_DONE);
  assign sum_valid = (state == S_DONE);
  assign take      = in_valid && in_ready;
  assign wb        = pipe_vld[LAT-1];
  assign wb_pos    = CW'(DEPTH - 1) - pipe_cnt[LAT-1] - CW'(take);
  assign red_end   = (state == S_RED) && (ridx == RW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_vld <= '0;
    end else begin
      pipe_vld[0] <= take;
      for (int i = 1; i < LAT; i++) pipe_vld[i] <= pipe_vld[i-1];
    end
    pipe_sum[0] <= lane[0] + in_data;
    pipe_cnt[0] <= '0;
    for (int i = 1; i < LAT; i++) begin
      pipe_sum[i] <= pipe_sum[i-1];
      pipe_cnt[i] <= pipe_cnt[i-1] + CW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || red_end) begin
      for (int j = 0; j < DEPTH; j++) lane[j] <= '0;
    end else begin
      if (take) begin
        for (int j = 0; j < DEPTH - 1; j++) lane[j] <= lane[j+1];
        lane[DEPTH-1] <= '0;
      end
      if (wb) lane[wb_pos] <= pipe_sum[LAT-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_ACC;
      ridx    <= '0;
      sum_out <= '0;
    end else begin
      case (state)
        S_ACC, S_DONE: state <= (take && in_last) ? S_DRAIN : S_ACC;
        S_DRAIN: if (pipe_vld == '0) begin
          state <= S_RED;
          ridx  <= '0;
        end
        S_RED: begin
          sum_out <= (ridx == '0) ? lane[0] : sum_out + lane[ridx];
          if (red_end) state <= S_DONE;
          else ridx <= ridx + 1'b1;
        end
        default: state <= S_ACC;
      endcase
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);

  a_r6_drop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_last));

  a_r2_stay_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=> in_ready);

  a_r3_reduce_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RED) |-> (pipe_vld == '0 && !in_ready));
endmodule

// File: tb/sim_ilv_accum.sv
module sim_ilv_accum;
  localparam int CLK_NS = 10;
  localparam int W = 16, L = 3, D = 4;

  logic clk = 0, rst_n = 0, in_valid = 0, in_last = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, sum_valid;
  logic [W-1:0] sum_out;

  ilv_accum #(.WIDTH(W), .LAT(L), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .sum_out(sum_out), .sum_valid(sum_valid));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R3";
  logic busy = 0, pulse = 0;
  int cd = 0;
  logic [W-1:0] acc = '0, res = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; pulse = 0; cd = 0; acc = '0;
    end else begin
      pulse = 0;
      if (!busy && in_valid) begin
        acc = acc + in_data;
        if (in_last) begin
          busy = 1; cd = L + D + 1; res = acc; acc = '0;
        end
      end else if (busy) begin
        cd = cd - 1;
        if (cd == 0) begin busy = 0; pulse = 1; end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (in_ready !== !busy) begin
      errors++; $display("FAIL R6 in_ready=%0b expected %0b", in_ready, !busy);
    end
    checks++;
    if (sum_valid !== pulse) begin
      errors++; $display("FAIL R5 sum_valid=%0b expected %0b", sum_valid, pulse);
    end
    if (pulse) begin
      checks++;
      if (sum_out !== res) begin
        errors++; $display("FAIL %s sum_out=%0h expected %0h", tag, sum_out, res);
      end
    end
  end

  task automatic op(input logic [W-1:0] d, input logic l);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_last = l;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    idle(L + D + 4);
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    idle(3);
    checks++;
    if (in_ready !== 1'b1 || sum_valid !== 1'b0) begin
      errors++; $display("FAIL R1 ready=%0b valid=%0b expected 1 0", in_ready, sum_valid);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || sum_valid !== 1'b0) begin
      errors++; $display("FAIL R1 ready=%0b valid=%0b expected 1 0", in_ready, sum_valid);
    end

    tag = "R2";
    for (int i = 1; i <= 10; i++) op(W'(i), i == 10);
    settle();

    tag = "R4";
    for (int i = 0; i < 9; i++) begin
      op(W'(100 + 7 * i), i == 8);
      if (i % 3 != 2) idle(i % 4 + 1);
    end

    tag = "R7";
    for (int i = 0; i < 6; i++) op(W'(3 * i + 1), i == 5);
    tag = "R7";
    for (int i = 0; i < 5; i++) op(W'(50 + i), i == 4);
    settle();

    tag = "R8";
    op(16'h1234, 1'b1);
    settle();
    op(16'h0042, 1'b1);
    op(16'h0007, 1'b1);
    settle();

    tag = "R9";
    for (int i = 0; i < 5; i++) op(16'hFFFF, i == 4);
    settle();
    for (int i = 0; i < 3; i++) op(16'h8001, i == 2);
    settle();

    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 37; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        op(lf, i == 36);
        if (lf[1:0] == 2'b00) idle(int'(lf[3:2]));
      end
    end
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule